// File: doc/BRIEF.md
# Sized Doorbell Write Generator

This block turns one doorbell request into at most one write on a 32-bit data bus with per-byte write enables. A request is a target address, an attribute byte and a 32-bit data word, presented together with a one-cycle start pulse. The attribute byte says whether a write is wanted at all and how wide it is: a full word, a half word or a single byte. The block checks that the address is naturally aligned to that width. It moves the meaningful low-order data bits onto the byte lanes that the address selects, issues the write with a valid/ready handshake, and pulses a done strobe once the write has been accepted.

A request with its write bit clear finishes at once, with no bus activity. A request that names the reserved width, or whose address is not aligned to the width it names, also makes no bus access. It completes with an error flag raised alongside done. Only one request is handled at a time. A start pulse that arrives while a write is still waiting for acceptance is dropped.

Top module: `bell_writer`

## Requirements
- R1: While reset is high, and in the cycle after it is released, `wr_valid_o`, `done_o` and `err_o` are all low.
- R2: When attribute bit 7 is 0, no write is issued whatever the other attribute bits and the address are. `done_o` is high for exactly one cycle, the cycle after the start edge, and `err_o` stays low.
- R3: Attribute bits 1:0 give the width: 0 is a 32-bit word with strobes 4'b1111. 1 is a 16-bit half word with strobes 4'b0011 when address bit 1 is 0 and 4'b1100 when it is 1. 2 is an 8-bit byte whose strobe is the single bit at index address[1:0].
- R4: A write of width 1 with address bit 0 set, or of width 0 with address bits 1:0 not zero, is not issued. `done_o` and `err_o` are then both high for the one cycle after the start edge.
- R5: Width code 3, with attribute bit 7 set, is not issued whatever the address. `done_o` and `err_o` are both high for the one cycle after the start edge.
- R6: `wr_addr_o` equals the requested address. The data is placed as follows. A word passes data[31:0] unchanged. A half word places data[15:0] on the byte lanes named by its strobes. A byte places data[7:0] on byte lane address[1:0]. Every byte lane whose strobe is 0 carries zero.
- R7: For a valid enabled request, `wr_valid_o` rises in the cycle after the start edge. While `wr_ready_i` is low, the valid signal and the address, data and strobes stay unchanged. In the cycle after the edge where valid and ready are both high, `wr_valid_o` is low and `done_o` is high for one cycle, with `err_o` low.
- R8: Attribute bits 6:2 have no effect on the decision to write, on the strobes, on the data or on the error flag.
- R9: A start pulse while `wr_valid_o` is high is ignored. The pending write keeps its address, data and strobes, and no second write or extra done pulse follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | One-cycle request strobe; request fields are sampled with it |
| addr_i | input | ADDR_W | Doorbell target address |
| attr_i | input | 8 | Attribute byte: bit 7 write enable, bits 1:0 width code |
| data_i | input | 32 | Doorbell data, low-order bits meaningful for narrow widths |
| wr_valid_o | output | 1 | Bus write request valid |
| wr_ready_i | input | 1 | Bus accepts the write on a cycle where valid is also high |
| wr_addr_o | output | ADDR_W | Bus write address |
| wr_data_o | output | 32 | Bus write data, placed on byte lanes |
| wr_strb_o | output | 4 | Bus byte write enables |
| done_o | output | 1 | One-cycle completion pulse for every accepted request |
| err_o | output | 1 | High with done when the request was rejected |

## Verification
The assertions assume that reset is applied from time zero. They also assume that `wr_ready_i` is only sampled at clock edges, so a pending write can stall for any number of cycles. They do not assume anything about when `start_i` pulses; pulses during a pending write are legal and must be dropped. The stimulus changes inputs only on falling edges and holds start for exactly one cycle. It walks every width code against each address offset that matters, including the reserved code and both misaligned cases. Ready is held low for at least one cycle on every issued write, so that the hold rules are exercised.

// File: rtl/bell_pkg.sv
package bell_pkg;

    localparam int unsigned LANES  = 4;
    localparam int unsigned LANE_W = 8;
    localparam int unsigned BUS_W  = LANES * LANE_W;
    localparam int unsigned OFF_W  = $clog2(LANES);

    typedef enum logic [1:0] {
        SZ_WORD = 2'd0,
        SZ_HALF = 2'd1,
        SZ_BYTE = 2'd2,
        SZ_RSVD = 2'd3
    } size_e;

    typedef struct packed {
        logic       fire;
        logic [4:0] spare;
        size_e      size;
    } attr_t;

    typedef struct packed {
        logic             write;
        logic             fault;
        logic [LANES-1:0] strb;
        logic [BUS_W-1:0] data;
    } plan_t;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_ISSUE = 1'b1
    } state_e;

    function automatic logic size_legal(input size_e sz);
        return sz != SZ_RSVD;
    endfunction

    function automatic logic offset_fits(input size_e sz, input logic [OFF_W-1:0] off);
        logic ok;
        unique case (sz)
            SZ_WORD: ok = (off == '0);
            SZ_HALF: ok = (off[0] == 1'b0);
            SZ_BYTE: ok = 1'b1;
            default: ok = 1'b0;
        endcase
        return ok;
    endfunction

endpackage

// File: rtl/bell_decode.sv
module bell_decode
    import bell_pkg::*;
#(
    parameter int unsigned ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        attr_raw,
    output logic              fire,
    output logic              fault,
    output size_e             size,
    output logic [OFF_W-1:0]  off
);

    attr_t attr;

    always_comb begin
        attr  = attr_t'(attr_raw);
        size  = attr.size;
        off   = addr[OFF_W-1:0];
        fire  = attr.fire;
        fault = attr.fire && (!size_legal(attr.size) || !offset_fits(attr.size, off));
    end

endmodule

// File: rtl/bell_lanes.sv
module bell_lanes
    import bell_pkg::*;
(
    input  size_e             size,
    input  logic [OFF_W-1:0]  off,
    input  logic [BUS_W-1:0]  data,
    output logic [LANES-1:0]  strb,
    output logic [BUS_W-1:0]  lane_data
);

    for (genvar j = 0; j < LANES; j++) begin : g_lane
        localparam logic [OFF_W-1:0] LANE_IDX = OFF_W'(j);
        localparam int unsigned      HALF_SRC = (j % 2) * LANE_W;
        localparam int unsigned      WORD_SRC = j * LANE_W;

        logic              hit;
        logic [LANE_W-1:0] src;

        always_comb begin
            unique case (size)
                SZ_WORD: begin
                    hit = 1'b1;
                    src = data[WORD_SRC +: LANE_W];
                end
                SZ_HALF: begin
                    hit = (off[OFF_W-1] == LANE_IDX[OFF_W-1]);
                    src = data[HALF_SRC +: LANE_W];
                end
                SZ_BYTE: begin
                    hit = (off == LANE_IDX);
                    src = data[LANE_W-1:0];
                end
                default: begin
                    hit = 1'b0;
                    src = '0;
                end
            endcase
        end

        assign strb[j]                         = hit;
        assign lane_data[WORD_SRC +: LANE_W]   = hit ? src : '0;
    end

endmodule

// File: rtl/bell_fsm.sv
module bell_fsm
    import bell_pkg::*;
#(
    parameter int unsigned ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  plan_t             plan,
    input  logic [ADDR_W-1:0] plan_addr,
    input  logic              wr_ready,
    output logic              wr_valid,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [BUS_W-1:0]  wr_data,
    output logic [LANES-1:0]  wr_strb,
    output logic              done,
    output logic              err
);

    state_e state;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            wr_valid <= 1'b0;
            wr_addr  <= '0;
            wr_data  <= '0;
            wr_strb  <= '0;
            done     <= 1'b0;
            err      <= 1'b0;
        end else begin
            done <= 1'b0;
            err  <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        if (plan.write) begin
                            wr_valid <= 1'b1;
                            wr_addr  <= plan_addr;
                            wr_data  <= plan.data;
                            wr_strb  <= plan.strb;
                            state    <= ST_ISSUE;
                        end else begin
                            done <= 1'b1;
                            err  <= plan.fault;
                        end
                    end
                end
                ST_ISSUE: begin
                    if (wr_ready) begin
                        wr_valid <= 1'b0;
                        done     <= 1'b1;
                        state    <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/bell_writer.sv
module bell_writer
    import bell_pkg::*;
#(
    parameter int unsigned ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [7:0]        attr_i,
    input  logic [BUS_W-1:0]  data_i,
    output logic              wr_valid_o,
    input  logic              wr_ready_i,
    output logic [ADDR_W-1:0] wr_addr_o,
    output logic [BUS_W-1:0]  wr_data_o,
    output logic [LANES-1:0]  wr_strb_o,
    output logic              done_o,
    output logic              err_o
);

    logic             fire;
    logic             fault;
    size_e            size;
    logic [OFF_W-1:0] off;
    logic [LANES-1:0] strb;
    logic [BUS_W-1:0] lane_data;
    plan_t            plan;

    bell_decode #(.ADDR_W(ADDR_W)) u_decode (
        .addr     (addr_i),
        .attr_raw (attr_i),
        .fire     (fire),
        .fault    (fault),
        .size     (size),
        .off      (off)
    );

    bell_lanes u_lanes (
        .size      (size),
        .off       (off),
        .data      (data_i),
        .strb      (strb),
        .lane_data (lane_data)
    );

    always_comb begin
        plan.write = fire && !fault;
        plan.fault = fault;
        plan.strb  = strb;
        plan.data  = lane_data;
    end

    bell_fsm #(.ADDR_W(ADDR_W)) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .start     (start_i),
        .plan      (plan),
        .plan_addr (addr_i),
        .wr_ready  (wr_ready_i),
        .wr_valid  (wr_valid_o),
        .wr_addr   (wr_addr_o),
        .wr_data   (wr_data_o),
        .wr_strb   (wr_strb_o),
        .done      (done_o),
        .err       (err_o)
    );

endmodule

// File: rtl/bell_writer_chk.sv
module bell_writer_chk
    import bell_pkg::*;
#(
    parameter int unsigned ADDR_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              start_i,
    input logic              wr_valid_o,
    input logic              wr_ready_i,
    input logic [ADDR_W-1:0] wr_addr_o,
    input logic [BUS_W-1:0]  wr_data_o,
    input logic [LANES-1:0]  wr_strb_o,
    input logic              done_o,
    input logic              err_o
);

    p_reset_quiet_r1: assert property (@(posedge clk)
        rst |=> (!wr_valid_o && !done_o && !err_o));

    p_err_with_done_r4: assert property (@(posedge clk) disable iff (rst)
        err_o |-> done_o);

    p_strb_width_r3: assert property (@(posedge clk) disable iff (rst)
        wr_valid_o |-> ($countones(wr_strb_o) == 1 || wr_strb_o == 4'b0011
                        || wr_strb_o == 4'b1100 || wr_strb_o == 4'b1111));

    p_word_aligned_r4: assert property (@(posedge clk) disable iff (rst)
        (wr_valid_o && wr_strb_o == 4'b1111) |-> (wr_addr_o[1:0] == 2'b00));

    p_half_aligned_r4: assert property (@(posedge clk) disable iff (rst)
        (wr_valid_o && $countones(wr_strb_o) == 2) |-> (wr_addr_o[0] == 1'b0
            && wr_strb_o[3] == wr_addr_o[1]));

    p_byte_lane_r3: assert property (@(posedge clk) disable iff (rst)
        (wr_valid_o && $countones(wr_strb_o) == 1) |-> (wr_strb_o == (4'b0001 << wr_addr_o[1:0])));

    p_idle_lanes_zero_r6: assert property (@(posedge clk) disable iff (rst)
        wr_valid_o |-> ((wr_strb_o[0] || wr_data_o[7:0]   == 8'h00) &&
                        (wr_strb_o[1] || wr_data_o[15:8]  == 8'h00) &&
                        (wr_strb_o[2] || wr_data_o[23:16] == 8'h00) &&
                        (wr_strb_o[3] || wr_data_o[31:24] == 8'h00)));

    p_hold_payload_r7: assert property (@(posedge clk) disable iff (rst)
        (wr_valid_o && !wr_ready_i) |=> (wr_valid_o && $stable(wr_addr_o)
            && $stable(wr_data_o) && $stable(wr_strb_o)));

    p_done_after_accept_r7: assert property (@(posedge clk) disable iff (rst)
        (wr_valid_o && wr_ready_i) |=> (done_o && !err_o && !wr_valid_o));

    p_start_dropped_r9: assert property (@(posedge clk) disable iff (rst)
        (wr_valid_o && !wr_ready_i && start_i) |=> (wr_valid_o && !done_o));

    p_done_excl_valid_r2: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !wr_valid_o);

endmodule

bind bell_writer bell_writer_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .start_i    (start_i),
    .wr_valid_o (wr_valid_o),
    .wr_ready_i (wr_ready_i),
    .wr_addr_o  (wr_addr_o),
    .wr_data_o  (wr_data_o),
    .wr_strb_o  (wr_strb_o),
    .done_o     (done_o),
    .err_o      (err_o)
);

// File: tb/bell_writer_test.sv
module bell_writer_test;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 32;
    localparam int NVEC       = 13;

    typedef struct packed {
        logic [31:0] addr;
        logic [7:0]  attr;
        logic [31:0] data;
        logic        wr;
        logic        err;
        logic [3:0]  strb;
        logic [31:0] wdata;
    } vec_t;

    // wr/err/strb/wdata worked out from R2..R8 by hand
    localparam vec_t VECS [NVEC] = '{
        '{32'h1000_0000, 8'h80, 32'hA1B2_C3D4, 1'b1, 1'b0, 4'hF, 32'hA1B2_C3D4}, // R3 word
        '{32'h1000_0002, 8'h81, 32'hA1B2_C3D4, 1'b1, 1'b0, 4'hC, 32'hC3D4_0000}, // R6 upper half
        '{32'h1000_0000, 8'h81, 32'hA1B2_C3D4, 1'b1, 1'b0, 4'h3, 32'h0000_C3D4}, // R6 lower half
        '{32'h1000_0001, 8'h81, 32'hA1B2_C3D4, 1'b0, 1'b1, 4'h0, 32'h0},         // R4 half odd
        '{32'h1000_0003, 8'h82, 32'hA1B2_C3D4, 1'b1, 1'b0, 4'h8, 32'hD400_0000}, // R6 byte 3
        '{32'h1000_0001, 8'h82, 32'hA1B2_C3D4, 1'b1, 1'b0, 4'h2, 32'h0000_D400}, // R6 byte 1
        '{32'h1000_0002, 8'h80, 32'hA1B2_C3D4, 1'b0, 1'b1, 4'h0, 32'h0},         // R4 word off 2
        '{32'h1000_0000, 8'h83, 32'hA1B2_C3D4, 1'b0, 1'b1, 4'h0, 32'h0},         // R5 reserved
        '{32'h1000_0000, 8'h03, 32'hA1B2_C3D4, 1'b0, 1'b0, 4'h0, 32'h0},         // R2 disabled
        '{32'h1000_0001, 8'h00, 32'hA1B2_C3D4, 1'b0, 1'b0, 4'h0, 32'h0},         // R2 disabled odd
        '{32'h2000_0002, 8'hFD, 32'h5566_7788, 1'b1, 1'b0, 4'hC, 32'h7788_0000}, // R8 spare bits
        '{32'h2000_0000, 8'h7E, 32'h5566_7788, 1'b0, 1'b0, 4'h0, 32'h0},         // R8 spare, disabled
        '{32'h2000_0000, 8'hFE, 32'h5566_7788, 1'b1, 1'b0, 4'h1, 32'h0000_0088}  // R8 byte 0
    };

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              start_i = 1'b0;
    logic [ADDR_W-1:0] addr_i = '0;
    logic [7:0]        attr_i = '0;
    logic [31:0]       data_i = '0;
    logic              wr_valid_o;
    logic              wr_ready_i = 1'b0;
    logic [ADDR_W-1:0] wr_addr_o;
    logic [31:0]       wr_data_o;
    logic [3:0]        wr_strb_o;
    logic              done_o;
    logic              err_o;

    int  n_tests  = 0;
    int  n_failed = 0;
    bit  finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bell_writer #(.ADDR_W(ADDR_W)) uut (
        .clk        (clk),
        .rst        (rst),
        .start_i    (start_i),
        .addr_i     (addr_i),
        .attr_i     (attr_i),
        .data_i     (data_i),
        .wr_valid_o (wr_valid_o),
        .wr_ready_i (wr_ready_i),
        .wr_addr_o  (wr_addr_o),
        .wr_data_o  (wr_data_o),
        .wr_strb_o  (wr_strb_o),
        .done_o     (done_o),
        .err_o      (err_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_failed++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic pulse_start(input logic [31:0] a, input logic [7:0] t, input logic [31:0] d);
        @(negedge clk);
        start_i = 1'b1;
        addr_i  = a;
        attr_i  = t;
        data_i  = d;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic run_vec(input vec_t v, input int idx);
        pulse_start(v.addr, v.attr, v.data);
        // now one cycle after the start edge
        if (v.wr) begin
            check($sformatf("R7 vec%0d valid", idx), 32'(wr_valid_o), 32'd1);
            check($sformatf("R3 vec%0d strb", idx), 32'(wr_strb_o), 32'(v.strb));
            check($sformatf("R6 vec%0d data", idx), wr_data_o, v.wdata);
            check($sformatf("R6 vec%0d addr", idx), wr_addr_o, v.addr);
            check($sformatf("R7 vec%0d no early done", idx), 32'(done_o), 32'd0);
            @(negedge clk);
            check($sformatf("R7 vec%0d held", idx), {wr_valid_o, wr_strb_o, wr_data_o[26:0]},
                  {1'b1, v.strb, v.wdata[26:0]});
            wr_ready_i = 1'b1;
            @(negedge clk);
            wr_ready_i = 1'b0;
            check($sformatf("R7 vec%0d done", idx), {30'd0, done_o, err_o}, 32'd2);
            check($sformatf("R7 vec%0d valid drop", idx), 32'(wr_valid_o), 32'd0);
        end else begin
            check($sformatf("R2 R4 R5 vec%0d no write", idx), 32'(wr_valid_o), 32'd0);
            check($sformatf("R2 R4 R5 vec%0d done/err", idx), {30'd0, done_o, err_o},
                  {30'd0, 1'b1, v.err});
        end
        @(negedge clk);
        check($sformatf("R2 R7 vec%0d single done", idx), {30'd0, done_o, wr_valid_o}, 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset valid", 32'(wr_valid_o), 32'd0);
        check("R1 reset done/err", {30'd0, done_o, err_o}, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 after release", {29'd0, wr_valid_o, done_o, err_o}, 32'd0);

        for (int i = 0; i < NVEC; i++) run_vec(VECS[i], i);

        // R9: second start while write pending is dropped
        pulse_start(32'h3000_0001, 8'h82, 32'h0000_00AB);
        check("R9 first issued", {wr_valid_o, wr_strb_o}, {1'b1, 4'h2});
        @(negedge clk);
        start_i = 1'b1;
        addr_i  = 32'h4000_0000;
        attr_i  = 8'h80;
        data_i  = 32'hFFFF_FFFF;
        @(negedge clk);
        start_i = 1'b0;
        check("R9 addr kept", wr_addr_o, 32'h3000_0001);
        check("R9 data kept", wr_data_o, 32'h0000_AB00);
        check("R9 strb kept", 32'(wr_strb_o), 32'h2);
        wr_ready_i = 1'b1;
        @(negedge clk);
        wr_ready_i = 1'b0;
        check("R9 done once", {30'd0, done_o, wr_valid_o}, 32'd2);
        repeat (2) begin
            @(negedge clk);
            check("R9 no second write", {30'd0, done_o, wr_valid_o}, 32'd0);
        end

        // R1: reset during a pending write clears it
        pulse_start(32'h3000_0000, 8'h80, 32'h1234_5678);
        check("R1 pending before reset", 32'(wr_valid_o), 32'd1);
        rst = 1'b1;
        @(negedge clk);
        check("R1 reset mid write", {29'd0, wr_valid_o, done_o, err_o}, 32'd0);
        rst = 1'b0;
        @(negedge clk);

        // R5: reserved code at odd address, still error
        run_vec('{32'h5000_0003, 8'hFF, 32'h0, 1'b0, 1'b1, 4'h0, 32'h0}, 99);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_failed);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_tests++;
            n_failed++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_failed);
            $finish;
        end
    end

endmodule